// File: doc/BRIEF.md
# Programmable DC-Restore Clamp Timer

This block works in the pixel-clock domain of a video digitiser front end. It watches the horizontal sync input and finds the edge where the pulse ends. It then counts a programmed number of pixels and raises a clamp pulse for a programmed number of pixels. The clamp drives the DC-restore switch on AC-coupled inputs. The start count is 16 bits wide, so the clamp can sit on the back porch after sync, or beyond the active pixels on the front porch.

The same per-line event has two other uses. It marks the black-level sampling window for the offset servo. It also moves the pending gain settings for the three colour channels into the active gain registers, so a gain written by software takes effect at most one line later. If sync disappears, a timeout still moves the pending gains across. The clamp output is held low in DC-coupled mode. It is also held low while the sync PLL is coasting, unless software allows clamping during coast.

Top module: `clamp_timer`

## Requirements
- R1: The sync polarity input selects the asserted level (`hs_pol_i`=1: high is asserted; 0: low is asserted). The trailing edge is the first clock edge at which `hsync_i` shows the deasserted level after showing the asserted level at the previous edge. Call this edge E0.
- R2: With AC coupling and no coast suppression, `clamp_o` is high after clock edges E0+S through E0+S+W-1 and low otherwise. S is `start_ofs_i` and W is `clamp_width_i`. The pulse is therefore exactly W cycles long.
- R3: Start counts far beyond the active line, up to 65535, are honoured, which places the clamp on the front porch. A pulse is produced on every line.
- R4: When `ac_coupled_i`=0 (DC coupling), `clamp_o` stays low.
- R5: When `coast_i`=1 and `clamp_in_coast_i`=0, `clamp_o` stays low. When `clamp_in_coast_i`=1, coast has no effect on the clamp.
- R6: `window_o` is high for exactly the one cycle after edge E0+S. This holds whatever the coupling and coast settings are.
- R7: A width of zero produces no clamp pulse, no `window_o` pulse and no gain transfer for that line.
- R8: On the same edge that raises `window_o`, `gain_o` takes the value of `gain_pend_i`. Channel c occupies bits [8c+7:8c]. Otherwise it keeps its value, except as R10 states.
- R9: A trailing edge that arrives while a line's count is still running restarts the count from zero. The unfinished pulse is abandoned.
- R10: If TMO_CYCLES clock edges pass with no trailing edge and no gain transfer, `gain_o` takes `gain_pend_i` at the TMO_CYCLES-th edge. The count starts from reset release.
- R11: After reset, `clamp_o` and `window_o` are low and every gain channel holds GAIN_RST (0x55 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync, synchronous to clk |
| hs_pol_i | input | 1 | 1: sync asserted high, 0: asserted low |
| coast_i | input | 1 | PLL coasting indicator |
| ac_coupled_i | input | 1 | 1: AC-coupled input, clamp enabled |
| clamp_in_coast_i | input | 1 | 1: allow clamp while coasting |
| start_ofs_i | input | START_W | Pixels from trailing edge to clamp start |
| clamp_width_i | input | WIDTH_W | Clamp length in pixels |
| gain_pend_i | input | NUM_CH*GAIN_W | Pending gain values, channel c at [GAIN_W*c +: GAIN_W] |
| clamp_o | output | 1 | DC-restore clamp pulse |
| window_o | output | 1 | One-cycle black-level window strobe |
| gain_o | output | NUM_CH*GAIN_W | Active gain values |

## Verification
The bench sweeps small start and width values against every combination of polarity, coupling, coast and coast override. A width of zero is included, where a design that counts one pixel too many would emit a one-cycle pulse or transfer gains. Offsets of zero are included, where an off-by-one start would show as a clamp that is one cycle late or one cycle early. A front-porch start of 300 shows whether the counter is too narrow or wraps. A sync pulse is cut short mid-clamp to show whether the design finishes the old pulse instead of restarting. The timeout transfer is checked one cycle before and at the expiry edge, which exposes an off-by-one in the timeout counter.

// File: rtl/clamp_timer_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the clamp timer.
package clamp_timer_pkg;
    typedef enum logic {
        HS_ACTIVE_LOW  = 1'b0,
        HS_ACTIVE_HIGH = 1'b1
    } hs_pol_e;
endpackage

// File: rtl/ct_hs_edge.sv
`timescale 1ns/1ps
// Trailing-edge detector for horizontal sync.
// Assumes hsync_i is already synchronous to clk. The output is a
// combinational pulse during the cycle in which the registered
// asserted state falls.
module ct_hs_edge
    import clamp_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_i,
    input  logic hs_pol_i,
    output logic trail_o
);
    logic asserted;
    logic asserted_q;

    // Normalise polarity so that 1 means "sync asserted".
    always_comb begin
        asserted = (hs_pol_e'(hs_pol_i) == HS_ACTIVE_HIGH) ? hsync_i : ~hsync_i;
    end

    // Remember the previous asserted state.
    always_ff @(posedge clk) begin
        if (!rst_n) asserted_q <= 1'b0;
        else        asserted_q <= asserted;
    end

    assign trail_o = asserted_q & ~asserted;
endmodule

// File: rtl/ct_line_counter.sv
`timescale 1ns/1ps
// Per-line pixel counter and window generator.
// A trailing edge loads the count with zero and starts it. The window
// covers counts start .. start+width-1. The counter stops at the window end.
// The counter is one bit wider than the start field, so start+width never
// wraps.
module ct_line_counter #(
    parameter int START_W = 16,
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trail_i,
    input  logic [START_W-1:0] start_i,
    input  logic [WIDTH_W-1:0] width_i,
    output logic               in_win_o,
    output logic               first_o,
    output logic               first_nxt_o
);
    localparam int CNT_W = START_W + 1;

    logic [CNT_W-1:0] cnt, cnt_n, start_ext, end_val;
    logic             running, run_n, win_n;

    assign start_ext = {1'b0, start_i};
    assign end_val   = start_ext + CNT_W'(width_i);

    // Next count, run state and window flags.
    always_comb begin
        cnt_n = cnt;
        run_n = running;
        if (trail_i) begin
            cnt_n = '0;
            run_n = 1'b1;
        end else if (running) begin
            cnt_n = cnt + 1'b1;
        end
        win_n       = run_n && (cnt_n >= start_ext) && (cnt_n < end_val);
        first_nxt_o = win_n && (cnt_n == start_ext);
        if (run_n && (cnt_n >= end_val)) run_n = 1'b0;
    end

    // State and registered window outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            running  <= 1'b0;
            in_win_o <= 1'b0;
            first_o  <= 1'b0;
        end else begin
            cnt      <= cnt_n;
            running  <= run_n;
            in_win_o <= win_n;
            first_o  <= first_nxt_o;
        end
    end
endmodule

// File: rtl/ct_timeout.sv
`timescale 1ns/1ps
// Sync-loss timeout. Counts edges since the last clear. When the count
// reaches TMO_CYCLES it pulses fire_o for one cycle and starts over.
module ct_timeout #(
    parameter int TMO_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic fire_o
);
    localparam int TMO_W = $clog2(TMO_CYCLES + 1);

    logic [TMO_W-1:0] cnt;

    assign fire_o = !clear_i && (cnt == TMO_W'(TMO_CYCLES - 1));

    // Count up, restarting on a clear or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (clear_i || fire_o) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ct_gain_latch.sv
`timescale 1ns/1ps
// Active gain registers, one per channel. All channels load from the
// pending bus together on load_i.
module ct_gain_latch #(
    parameter int             NUM_CH   = 3,
    parameter int             GAIN_W   = 8,
    parameter logic [GAIN_W-1:0] GAIN_RST = 8'h55
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [NUM_CH*GAIN_W-1:0] pend_i,
    output logic [NUM_CH*GAIN_W-1:0] gain_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Channel c transfer register.
        always_ff @(posedge clk) begin
            if (!rst_n)      gain_o[c*GAIN_W +: GAIN_W] <= GAIN_RST;
            else if (load_i) gain_o[c*GAIN_W +: GAIN_W] <= pend_i[c*GAIN_W +: GAIN_W];
        end
    end
endmodule

// File: rtl/clamp_timer.sv
`timescale 1ns/1ps
// DC-restore clamp timer.
// Produces a per-line clamp pulse placed relative to the sync trailing
// edge, a black-level window strobe, and the once-per-line gain transfer.
// The clamp is gated live by the coupling mode and by coast.
// Assumes that all inputs are synchronous to clk.
module clamp_timer #(
    parameter int                START_W    = 16,
    parameter int                WIDTH_W    = 8,
    parameter int                NUM_CH     = 3,
    parameter int                GAIN_W     = 8,
    parameter logic [GAIN_W-1:0] GAIN_RST   = 8'h55,
    parameter int                TMO_CYCLES = 4096
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hsync_i,
    input  logic                     hs_pol_i,
    input  logic                     coast_i,
    input  logic                     ac_coupled_i,
    input  logic                     clamp_in_coast_i,
    input  logic [START_W-1:0]       start_ofs_i,
    input  logic [WIDTH_W-1:0]       clamp_width_i,
    input  logic [NUM_CH*GAIN_W-1:0] gain_pend_i,
    output logic                     clamp_o,
    output logic                     window_o,
    output logic [NUM_CH*GAIN_W-1:0] gain_o
);
    logic trail, in_win, line_evt, tmo_fire;

    ct_hs_edge u_edge (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i),
        .hs_pol_i(hs_pol_i), .trail_o(trail)
    );

    ct_line_counter #(.START_W(START_W), .WIDTH_W(WIDTH_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .trail_i(trail),
        .start_i(start_ofs_i), .width_i(clamp_width_i),
        .in_win_o(in_win), .first_o(window_o), .first_nxt_o(line_evt)
    );

    ct_timeout #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
        .clk(clk), .rst_n(rst_n), .clear_i(trail | line_evt), .fire_o(tmo_fire)
    );

    ct_gain_latch #(.NUM_CH(NUM_CH), .GAIN_W(GAIN_W), .GAIN_RST(GAIN_RST)) u_gain (
        .clk(clk), .rst_n(rst_n), .load_i(line_evt | tmo_fire),
        .pend_i(gain_pend_i), .gain_o(gain_o)
    );

    // Clamp only when AC-coupled and not blocked by coast.
    always_comb begin
        clamp_o = in_win && ac_coupled_i && (clamp_in_coast_i || !coast_i);
    end
endmodule

// File: rtl/clamp_timer_chk.sv
`timescale 1ns/1ps
// Property checker for clamp_timer, attached by bind.
module clamp_timer_chk #(
    parameter int NUM_CH  = 3,
    parameter int GAIN_W  = 8,
    parameter int WIDTH_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ac_coupled_i,
    input logic                     coast_i,
    input logic                     clamp_in_coast_i,
    input logic [WIDTH_W-1:0]       clamp_width_i,
    input logic                     clamp_o,
    input logic                     window_o,
    input logic [NUM_CH*GAIN_W-1:0] gain_pend_i,
    input logic [NUM_CH*GAIN_W-1:0] gain_o,
    input logic                     tmo_fire
);
    assert_dc_no_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ac_coupled_i |-> !clamp_o);

    assert_coast_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (coast_i && !clamp_in_coast_i) |-> !clamp_o);

    assert_window_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        window_o |=> !window_o);

    assert_zero_width_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        window_o |-> ($past(clamp_width_i) != '0));

    assert_gain_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_o != $past(gain_o)) |-> (window_o || $past(tmo_fire)));

    assert_gain_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_o != $past(gain_o)) |-> (gain_o == $past(gain_pend_i)));
endmodule

bind clamp_timer clamp_timer_chk #(
    .NUM_CH(NUM_CH), .GAIN_W(GAIN_W), .WIDTH_W(WIDTH_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ac_coupled_i(ac_coupled_i), .coast_i(coast_i),
    .clamp_in_coast_i(clamp_in_coast_i), .clamp_width_i(clamp_width_i),
    .clamp_o(clamp_o), .window_o(window_o), .gain_pend_i(gain_pend_i),
    .gain_o(gain_o), .tmo_fire(tmo_fire)
);

// File: tb/clamp_timer_bench.sv
`timescale 1ns/1ps
module clamp_timer_bench;
    localparam int TMO = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync = 1'b0, pol = 1'b1, coast = 1'b0, ac = 1'b1, cic = 1'b0;
    logic [15:0] start = '0;
    logic [7:0]  width = '0;
    logic [23:0] pend = 24'h123456;
    logic        clamp, window;
    logic [23:0] gain;

    int vectors = 0, miscompares = 0;
    bit done = 0;
    logic [23:0] exp_prev;

    always #5 clk = ~clk;

    clamp_timer #(.TMO_CYCLES(TMO)) u_clamp_timer (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .hs_pol_i(pol),
        .coast_i(coast), .ac_coupled_i(ac), .clamp_in_coast_i(cic),
        .start_ofs_i(start), .clamp_width_i(width), .gain_pend_i(pend),
        .clamp_o(clamp), .window_o(window), .gain_o(gain)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive an asserted sync pulse of len cycles. E0 is the next posedge.
    task automatic sync_pulse(input int len);
        @(negedge clk);
        hsync = pol;
        repeat (len) @(negedge clk);
        hsync = ~pol;
    endtask

    // Sample edges E0 .. E0+last and compare against the arithmetic model.
    task automatic sample_line(input int s, input int w, input int last, input string ctag);
        for (int n = 0; n <= last; n++) begin
            logic in_w, e_clamp, e_win;
            logic [23:0] e_gain;
            @(posedge clk); #1;
            in_w    = (n >= s) && (n < s + w);
            e_clamp = in_w && ac && (cic || !coast);
            e_win   = (w != 0) && (n == s);
            e_gain  = ((w != 0) && (n >= s)) ? pend : exp_prev;
            check(ctag, clamp, e_clamp);
            check((w == 0) ? "R7 window" : "R6 window", window, e_win);
            check((w == 0) ? "R7 gain" : "R8 gain", gain, e_gain);
        end
        if (w != 0) exp_prev = pend;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R11: reset state
        check("R11 clamp", clamp, 0);
        check("R11 window", window, 0);
        check("R11 gain", gain, 24'h555555);
        rst_n = 1'b1;
        // R10: timeout transfer with no sync
        repeat (TMO - 1) @(posedge clk);
        #1 check("R10 before expiry", gain, 24'h555555);
        @(posedge clk); #1 check("R10 at expiry", gain, pend);
        exp_prev = pend;

        // Sweep: polarity, coupling, coast, override, start, width
        for (int cfg = 0; cfg < 16; cfg++) begin
            for (int s = 0; s <= 5; s++) begin
                for (int w = 0; w <= 4; w++) begin
                    string tag;
                    @(negedge clk);
                    pol   = cfg[0]; ac = cfg[1]; coast = cfg[2]; cic = cfg[3];
                    start = 16'(s); width = 8'(w);
                    pend  = {8'(cfg * 7 + s), 8'(w * 29 + cfg), 8'(s * 13 + w + 1)};
                    hsync = ~pol;
                    if (!ac)                tag = "R4 clamp";
                    else if (coast && !cic) tag = "R5 clamp";
                    else if (w == 0)        tag = "R7 clamp";
                    else if (!pol)          tag = "R1 clamp";
                    else                    tag = "R2 clamp";
                    sync_pulse(3);
                    sample_line(s, w, s + w + 2, tag);
                end
            end
        end

        // R3: front-porch start
        @(negedge clk);
        pol = 1; ac = 1; coast = 0; cic = 0; start = 16'd300; width = 8'd3;
        pend = 24'hA1B2C3; hsync = 0;
        sync_pulse(4);
        sample_line(300, 3, 305, "R3 clamp");
        // R3: next line again produces the pulse
        sync_pulse(2);
        sample_line(300, 3, 305, "R3 clamp repeat");

        // R9: restart in mid-clamp
        @(negedge clk);
        start = 16'd4; width = 8'd6; pend = 24'h0F1E2D;
        sync_pulse(2);
        sample_line(4, 6, 5, "R9 first part");
        sync_pulse(2);
        sample_line(4, 6, 12, "R9 restart");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule